// File: doc/BRIEF.md
# Automatic transmit/receive pin switcher

This block produces the output values for several banks of daughterboard I/O pins. Each bank has 16 pins. A per-bit mask decides where each pin gets its value. A pin with its mask bit clear is driven from that bank's ordinary output register. A pin with its mask bit set follows one of two preset patterns: the transmit pattern while the block is in the transmit state, and the receive pattern while it is in the receive state. The state follows a single "transmit FIFO holds data" flag.

Entering the transmit state and returning to the receive state are each held back by their own programmable tick count. If the flag reverses before a pending delay runs out, the state stays as it is and the delay starts again from zero. A global enable switches the automatic behaviour on. While it is off, every pin simply shows its ordinary output register.

Software sets up the block through a plain register write port. The FIFO flag is a level input. The pin word is a plain level output, and output-enable direction control is handled elsewhere. The block has no data stream, so it has no valid/ready handshake.

Top module: `atr_pin_switcher`

## Requirements
- R1: A synchronous active-high reset clears every register and puts the block in the receive state. All pin outputs read 0 after reset.
- R2: While the enable bit (bit 0 of the control register) is 0, every pin of bank b equals bank b's output register, whatever the state, mask or patterns.
- R3: While enabled, a pin whose mask bit is 0 equals the matching bit of its bank's output register.
- R4: While enabled, a pin whose mask bit is 1 takes the transmit pattern bit in the transmit state and the receive pattern bit in the receive state.
- R5: The block enters the transmit state when the FIFO flag has been 1 at N+1 consecutive clock edges, where N is the rise delay. With N=0 the state changes on the first clock edge that sees the flag.
- R6: The block returns to the receive state when the flag has been 0 at M+1 consecutive clock edges, where M is the separately programmed fall delay.
- R7: If the flag returns to the current state's value before a pending delay expires, the state does not change and the count restarts from zero at the next opposite-going change.
- R8: Each bank has its own output register, mask and patterns. A write to one bank leaves every other bank's pins unchanged. Bank b occupies bits [16b+15:16b] of pins_o.
- R9: The write address is {group, field}, with the field in the low 2 bits. Group 0 holds the global registers: field 0 is control, field 1 is the rise delay and field 2 is the fall delay (low 12 bits of wr_data). Group b+1 holds bank b: field 0 is the output register, 1 the mask, 2 the transmit pattern and 3 the receive pattern. A write is visible on pins_o right after the clock edge that captures it. Writes to groups above the last bank have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address {group, field} |
| wr_data | input | 16 | Register write data |
| tx_fifo_nonempty | input | 1 | High while the transmit FIFO holds data |
| pins_o | output | 64 | Pin values, 16 per bank |

## Verification
The hardest case to reach from the ports is a flag that reverses while a delay is still counting. In that case the state must stay put and the count must start over. The internal state has no port of its own, so the bench gives bank 0 a full mask, an all-ones transmit pattern and an all-zeros receive pattern, which puts the state directly on sixteen pins. It then raises the flag for fewer edges than the rise delay, drops it for one edge and raises it again. It checks that the flip comes a full N+1 edges after the second rise. A behavioural model compares every pin on every clock throughout.

// File: rtl/atr_pkg.sv
package atr_pkg;
  localparam int FIELD_W = 2;

  typedef enum logic [FIELD_W-1:0] {
    G_CTRL = 2'd0,
    G_RISE = 2'd1,
    G_FALL = 2'd2
  } glob_field_e;

  typedef enum logic [FIELD_W-1:0] {
    B_OUT   = 2'd0,
    B_MASK  = 2'd1,
    B_TXPAT = 2'd2,
    B_RXPAT = 2'd3
  } bank_field_e;
endpackage

// File: rtl/atr_regfile.sv
module atr_regfile
  import atr_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int PIN_W     = 16,
  parameter int DLY_W     = 12,
  parameter int ADDR_W    = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [PIN_W-1:0]                  wr_data,
  output logic                              enable_o,
  output logic [DLY_W-1:0]                  rise_dly_o,
  output logic [DLY_W-1:0]                  fall_dly_o,
  output logic [NUM_BANKS-1:0][PIN_W-1:0]   out_reg_o,
  output logic [NUM_BANKS-1:0][PIN_W-1:0]   mask_o,
  output logic [NUM_BANKS-1:0][PIN_W-1:0]   txpat_o,
  output logic [NUM_BANKS-1:0][PIN_W-1:0]   rxpat_o
);
  localparam int GRP_W = ADDR_W - FIELD_W;

  logic [GRP_W-1:0]   grp;
  logic [FIELD_W-1:0] fld;
  logic               glob_hit;

  assign grp      = wr_addr[ADDR_W-1:FIELD_W];
  assign fld      = wr_addr[FIELD_W-1:0];
  assign glob_hit = wr_en && (grp == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_o   <= 1'b0;
      rise_dly_o <= '0;
      fall_dly_o <= '0;
    end else if (glob_hit) begin
      case (fld)
        G_CTRL:  enable_o   <= wr_data[0];
        G_RISE:  rise_dly_o <= wr_data[DLY_W-1:0];
        G_FALL:  fall_dly_o <= wr_data[DLY_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_hit;
    assign bank_hit = wr_en && (grp == GRP_W'(b + 1));

    always_ff @(posedge clk) begin
      if (rst) begin
        out_reg_o[b] <= '0;
        mask_o[b]    <= '0;
        txpat_o[b]   <= '0;
        rxpat_o[b]   <= '0;
      end else if (bank_hit) begin
        case (fld)
          B_OUT:   out_reg_o[b] <= wr_data;
          B_MASK:  mask_o[b]    <= wr_data;
          B_TXPAT: txpat_o[b]   <= wr_data;
          B_RXPAT: rxpat_o[b]   <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // R9: a control write lands in the enable bit on the next edge
  a_r9_ctrl_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(0)) |=> (enable_o == $past(wr_data[0])));
endmodule

// File: rtl/atr_tr_timer.sv
module atr_tr_timer #(
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_ne,
  input  logic [DLY_W-1:0] rise_dly,
  input  logic [DLY_W-1:0] fall_dly,
  output logic             tx_state_o
);
  logic             tr_q;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] limit;
  logic             pending;

  assign limit   = tr_q ? fall_dly : rise_dly;
  assign pending = (fifo_ne != tr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      tr_q  <= 1'b0;
      cnt_q <= '0;
    end else if (pending) begin
      if (cnt_q >= limit) begin
        tr_q  <= fifo_ne;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign tx_state_o = tr_q;

  // R1: reset forces the receive state
  a_r1_reset_rx: assert property (@(posedge clk) rst |=> !tr_q);
  // R7: no state change while the flag agrees with the state
  a_r7_hold_on_match: assert property (@(posedge clk) disable iff (rst)
    (tr_q == fifo_ne) |=> $stable(tr_q));
  // R5: a nonzero rise delay never flips on the first sighting
  a_r5_rise_waits: assert property (@(posedge clk) disable iff (rst)
    (!tr_q && fifo_ne && rise_dly != '0 && cnt_q == '0) |=> !tr_q);
  // R6: a nonzero fall delay never flips on the first sighting
  a_r6_fall_waits: assert property (@(posedge clk) disable iff (rst)
    (tr_q && !fifo_ne && fall_dly != '0 && cnt_q == '0) |=> tr_q);
endmodule

// File: rtl/atr_pin_merge.sv
module atr_pin_merge #(
  parameter int PIN_W = 16
) (
  input  logic             enable,
  input  logic             tx_state,
  input  logic [PIN_W-1:0] out_reg,
  input  logic [PIN_W-1:0] mask,
  input  logic [PIN_W-1:0] txpat,
  input  logic [PIN_W-1:0] rxpat,
  output logic [PIN_W-1:0] pins
);
  logic [PIN_W-1:0] pattern;
  logic [PIN_W-1:0] sel;

  assign pattern = tx_state ? txpat : rxpat;
  assign sel     = enable ? mask : '0;
  assign pins    = (sel & pattern) | (~sel & out_reg);
endmodule

// File: rtl/atr_pin_switcher.sv
module atr_pin_switcher #(
  parameter int NUM_BANKS = 4,
  parameter int PIN_W     = 16,
  parameter int DLY_W     = 12,
  localparam int ADDR_W   = atr_pkg::FIELD_W + $clog2(NUM_BANKS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [PIN_W-1:0]           wr_data,
  input  logic                       tx_fifo_nonempty,
  output logic [NUM_BANKS*PIN_W-1:0] pins_o
);
  logic                            enable;
  logic [DLY_W-1:0]                rise_dly;
  logic [DLY_W-1:0]                fall_dly;
  logic [NUM_BANKS-1:0][PIN_W-1:0] out_reg;
  logic [NUM_BANKS-1:0][PIN_W-1:0] mask;
  logic [NUM_BANKS-1:0][PIN_W-1:0] txpat;
  logic [NUM_BANKS-1:0][PIN_W-1:0] rxpat;
  logic                            tx_state;

  atr_regfile #(
    .NUM_BANKS(NUM_BANKS), .PIN_W(PIN_W), .DLY_W(DLY_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .enable_o(enable), .rise_dly_o(rise_dly), .fall_dly_o(fall_dly),
    .out_reg_o(out_reg), .mask_o(mask), .txpat_o(txpat), .rxpat_o(rxpat)
  );

  atr_tr_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst(rst), .fifo_ne(tx_fifo_nonempty),
    .rise_dly(rise_dly), .fall_dly(fall_dly), .tx_state_o(tx_state)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_merge
    atr_pin_merge #(.PIN_W(PIN_W)) u_merge (
      .enable(enable), .tx_state(tx_state), .out_reg(out_reg[b]),
      .mask(mask[b]), .txpat(txpat[b]), .rxpat(rxpat[b]),
      .pins(pins_o[b*PIN_W +: PIN_W])
    );
  end
endmodule

// File: tb/sim_atr_pin_switcher.sv
module sim_atr_pin_switcher;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int PW = 16;
  localparam int AW = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [PW-1:0]   wr_data = '0;
  logic            fifo = 1'b0;
  logic [NB*PW-1:0] pins;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;
  string phase = "R1";

  // behavioural reference state
  logic [PW-1:0] m_io[NB], m_mask[NB], m_tx[NB], m_rx[NB];
  logic          m_en = 1'b0;
  int            m_rise = 0, m_fall = 0, m_run = 0;
  logic          m_tr = 1'b0;

  atr_pin_switcher u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_fifo_nonempty(fifo), .pins_o(pins)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial for (int i = 0; i < NB; i++) begin
    m_io[i] = '0; m_mask[i] = '0; m_tx[i] = '0; m_rx[i] = '0;
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) begin
        m_io[i] = '0; m_mask[i] = '0; m_tx[i] = '0; m_rx[i] = '0;
      end
      m_en = 0; m_rise = 0; m_fall = 0; m_run = 0; m_tr = 0;
    end else begin
      // delay uses the values held before this edge's write
      if (fifo != m_tr) begin
        if (m_run >= (m_tr ? m_fall : m_rise)) begin
          m_tr = fifo; m_run = 0;
        end else m_run++;
      end else m_run = 0;
      if (wr_en) begin
        int g, f;
        g = int'(wr_addr) / 4; f = int'(wr_addr) % 4;
        if (g == 0) begin
          if (f == 0) m_en = wr_data[0];
          else if (f == 1) m_rise = int'(wr_data[11:0]);
          else if (f == 2) m_fall = int'(wr_data[11:0]);
        end else if (g <= NB) begin
          case (f)
            0: m_io[g-1] = wr_data;
            1: m_mask[g-1] = wr_data;
            2: m_tx[g-1] = wr_data;
            default: m_rx[g-1] = wr_data;
          endcase
        end
      end
    end
  end

  function automatic logic [NB*PW-1:0] model_pins();
    logic [NB*PW-1:0] r;
    for (int i = 0; i < NB; i++) begin
      if (m_en) r[i*PW +: PW] = (m_mask[i] & (m_tr ? m_tx[i] : m_rx[i])) | (~m_mask[i] & m_io[i]);
      else      r[i*PW +: PW] = m_io[i];
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    logic [NB*PW-1:0] e;
    e = model_pins();
    check(pins === e, {phase, " model"}, pins, e);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic adv(int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int addr, int data);
    wr_en = 1; wr_addr = AW'(addr); wr_data = PW'(data);
    adv(1);
    wr_en = 0;
  endtask

  function automatic int ba(int b, int f);
    return (b + 1) * 4 + f;
  endfunction

  function automatic logic [15:0] bank(int b);
    return pins[b*PW +: PW];
  endfunction

  initial begin
    logic [63:0] snap;
    adv(3);
    check(pins === '0, "R1 reset pins", pins, 0);
    rst = 0; cmp_on = 1;

    phase = "R9";
    wr(ba(1, 0), 16'h1234);
    check(bank(1) === 16'h1234, "R9 write visible next edge", bank(1), 16'h1234);
    wr(ba(0, 0), 16'h00F0); wr(ba(2, 0), 16'hBEEF); wr(ba(3, 0), 16'h0F0F);
    wr(ba(1, 1), 16'h00FF); wr(ba(1, 2), 16'hA5A5); wr(ba(1, 3), 16'h3C3C);
    phase = "R2";
    check(bank(1) === 16'h1234, "R2 disabled shows output reg", bank(1), 16'h1234);

    wr(ba(0, 1), 16'hFFFF); wr(ba(0, 2), 16'hFFFF); wr(ba(0, 3), 16'h0000);
    wr(0, 1);
    phase = "R3";
    check(bank(1) === 16'h123C, "R3/R4 rx merge", bank(1), 16'h123C);
    check(bank(0) === 16'h0000, "R4 full mask rx", bank(0), 16'h0000);

    phase = "R5";
    fifo = 1; adv(1);
    check(bank(0) === 16'hFFFF, "R5 zero rise delay", bank(0), 16'hFFFF);
    check(bank(1) === 16'h12A5, "R4 tx merge", bank(1), 16'h12A5);
    phase = "R6";
    fifo = 0; adv(1);
    check(bank(0) === 16'h0000, "R6 zero fall delay", bank(0), 16'h0000);

    wr(1, 3); wr(2, 5);
    phase = "R5";
    fifo = 1; adv(3);
    check(bank(0) === 16'h0000, "R5 still rx after 3 edges", bank(0), 0);
    adv(1);
    check(bank(0) === 16'hFFFF, "R5 tx after 4 edges", bank(0), 16'hFFFF);
    phase = "R6";
    fifo = 0; adv(5);
    check(bank(0) === 16'hFFFF, "R6 still tx after 5 edges", bank(0), 16'hFFFF);
    adv(1);
    check(bank(0) === 16'h0000, "R6 rx after 6 edges", bank(0), 0);

    phase = "R7";
    fifo = 1; adv(2);
    fifo = 0; adv(1);
    check(bank(0) === 16'h0000, "R7 glitch no flip", bank(0), 0);
    fifo = 1; adv(3);
    check(bank(0) === 16'h0000, "R7 count restarted", bank(0), 0);
    adv(1);
    check(bank(0) === 16'hFFFF, "R7 flip after full delay", bank(0), 16'hFFFF);

    phase = "R8";
    snap = pins;
    wr(ba(3, 1), 16'hFF00); wr(ba(3, 2), 16'hC3C3);
    check(pins[47:0] === snap[47:0], "R8 other banks untouched", pins[47:0], snap[47:0]);
    check(bank(3) === 16'hC30F, "R8 bank3 merged", bank(3), 16'hC30F);

    phase = "R9";
    snap = pins;
    wr(5 * 4 + 1, 16'hFFFF); wr(5 * 4 + 0, 16'h5555);
    check(pins === snap, "R9 unmapped group ignored", pins, snap);

    phase = "R2";
    wr(0, 0);
    check(bank(0) === 16'h00F0, "R2 disabled in tx state", bank(0), 16'h00F0);
    check(bank(3) === 16'h0F0F, "R2 disabled bank3", bank(3), 16'h0F0F);

    phase = "R1";
    cmp_on = 0; rst = 1; adv(1);
    check(pins === '0, "R1 reset mid run", pins, 0);
    rst = 0; fifo = 0; cmp_on = 1; adv(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule